// File: doc/BRIEF.md
# Flag Compare and Branch Resolution Unit

This unit sits in the execute stage of a simple in-order integer core. It evaluates set-flag compare operations on two operands, producing the single condition flag. It also resolves every control transfer that depends on that flag or on nothing at all: conditional branches on flag set or flag clear, relative jumps, register jumps, and the two linking forms. The same flag selects between two operands for a conditional move.

One operation is accepted per clock while `opValid` is high. Results appear on the registered outputs one clock after the operation is presented. A high `taken` output tells the fetch logic two things: the instruction after the transfer is a delay slot that still executes, and `target` holds the address to continue from afterwards. Fetch, flushing and prediction belong to the surrounding core.

Top module: `fcb_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output except `linkIdx` is zero; `linkIdx` always equals parameter `LINK_REG` (default 9).
- R2: Signed compares read both operands as two's complement and write the flag: code 3 greater, 4 greater-or-equal, 5 less, 6 less-or-equal; the flag is 0 when the relation is false.
- R3: Unsigned compares write the flag: code 7 greater, 8 greater-or-equal, 9 less, 10 less-or-equal; the flag is 0 when the relation is false.
- R4: Code 1 sets the flag when the operands are equal and code 2 sets it when they differ; otherwise the flag is cleared.
- R5: Any accepted operation that is not a compare, and any cycle with `opValid` low, gives `flagOut` equal to the `flagIn` of that cycle.
- R6: Code 11 (branch on flag) is taken only when `flagIn` is 1 and code 12 (branch on no flag) only when `flagIn` is 0. The target of a taken branch is `pc` plus the sign-extended 26-bit `offset` times 4, modulo 2^32.
- R7: Code 13 (jump) and code 14 (jump and link) are always taken, whatever `flagIn` is, with the same relative target as R6.
- R8: Code 15 (register jump) and code 16 (register jump and link) are always taken, with `target` equal to `regTarget`.
- R9: Codes 14 and 16 raise `linkWe` with `linkData` equal to `pc` + 8. All other operations leave `linkWe` and `linkData` at zero.
- R10: When `taken` is 0, `target` is zero.
- R11: Code 17 (conditional move) raises `cmovValid` and gives `cmovData` = `opA` when `flagIn` is 1, else `opB`. All other operations leave both outputs at zero.
- R12: With `opValid` low, or an unassigned code (0 or 18 to 31), `taken`, `linkWe` and `cmovValid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 5 | Operation code (see requirements) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| pc | input | 32 | Address of the current instruction |
| offset | input | 26 | Signed word offset for relative transfers |
| regTarget | input | 32 | Target address for register jumps |
| flagIn | input | 1 | Current condition flag |
| flagOut | output | 1 | New condition flag |
| taken | output | 1 | Transfer taken; next instruction is a delay slot |
| target | output | 32 | Address after the delay slot |
| linkWe | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register index |
| linkData | output | 32 | Return address written to the link register |
| cmovValid | output | 1 | Conditional move result valid |
| cmovData | output | 32 | Conditional move result |

## Verification
Every output is registered, and no state carries from one operation to the next. A wrong decode or compare therefore shows at the ports exactly one clock after the faulty operation, and it shows only for that operation. The sweep applies all ten compares to operand pairs that straddle the sign boundary and zero, where swapping a signed and an unsigned ordering flips the flag. Branches, jumps and the conditional move each run with both flag values, so a reversed polarity or an ignored flag appears on the very next cycle.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  typedef enum logic [4:0] {
    OP_NONE   = 5'd0,
    OP_CMP_EQ = 5'd1,
    OP_CMP_NE = 5'd2,
    OP_CMP_GTS = 5'd3,
    OP_CMP_GES = 5'd4,
    OP_CMP_LTS = 5'd5,
    OP_CMP_LES = 5'd6,
    OP_CMP_GTU = 5'd7,
    OP_CMP_GEU = 5'd8,
    OP_CMP_LTU = 5'd9,
    OP_CMP_LEU = 5'd10,
    OP_BR_SET = 5'd11,
    OP_BR_CLR = 5'd12,
    OP_JMP    = 5'd13,
    OP_JMP_LNK = 5'd14,
    OP_JREG   = 5'd15,
    OP_JREG_LNK = 5'd16,
    OP_CMOV   = 5'd17
  } op_code_t;

  typedef enum logic [3:0] {
    CK_EQ, CK_NE, CK_GTS, CK_GES, CK_LTS, CK_LES,
    CK_GTU, CK_GEU, CK_LTU, CK_LEU
  } cmp_kind_t;

  typedef struct packed {
    logic      cmpEn;
    cmp_kind_t cmpKind;
    logic      brCond;
    logic      brOnSet;
    logic      jumpEn;
    logic      useReg;
    logic      linkEn;
    logic      cmovEn;
  } ctl_t;

endpackage

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import fcb_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output ctl_t            ctl
);

  always_comb begin
    ctl = '0;
    ctl.cmpKind = CK_EQ;
    if (opValid) begin
      case (opCode)
        OP_CMP_EQ:  begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_EQ;  end
        OP_CMP_NE:  begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_NE;  end
        OP_CMP_GTS: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_GTS; end
        OP_CMP_GES: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_GES; end
        OP_CMP_LTS: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_LTS; end
        OP_CMP_LES: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_LES; end
        OP_CMP_GTU: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_GTU; end
        OP_CMP_GEU: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_GEU; end
        OP_CMP_LTU: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_LTU; end
        OP_CMP_LEU: begin ctl.cmpEn = 1'b1; ctl.cmpKind = CK_LEU; end
        OP_BR_SET:  begin ctl.brCond = 1'b1; ctl.brOnSet = 1'b1; end
        OP_BR_CLR:  begin ctl.brCond = 1'b1; ctl.brOnSet = 1'b0; end
        OP_JMP:     begin ctl.jumpEn = 1'b1; end
        OP_JMP_LNK: begin ctl.jumpEn = 1'b1; ctl.linkEn = 1'b1; end
        OP_JREG:    begin ctl.jumpEn = 1'b1; ctl.useReg = 1'b1; end
        OP_JREG_LNK: begin ctl.jumpEn = 1'b1; ctl.useReg = 1'b1; ctl.linkEn = 1'b1; end
        OP_CMOV:    begin ctl.cmovEn = 1'b1; end
        default:    ctl = ctl;
      endcase
    end
  end

  // R12: at most one operation class decoded per cycle
  always_comb begin
    a_r12_one_class: assert ($onehot0({ctl.cmpEn, ctl.brCond, ctl.jumpEn, ctl.cmovEn}));
  end

endmodule

// File: rtl/fcb_datapath.sv
module fcb_datapath
  import fcb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic              flagIn,
  output logic              flagOut,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [ADDR_W-1:0] linkData,
  output logic              cmovValid,
  output logic [DATA_W-1:0] cmovData
);

  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam logic [ADDR_W-1:0] LINK_STEP = ADDR_W'(8);

  logic eqV, ltS, ltU, cmpRes;
  logic flagNext, takenNext;
  logic [ADDR_W-1:0] relTarget, targetNext;

  always_comb begin
    eqV = (opA == opB);
    ltS = ($signed(opA) < $signed(opB));
    ltU = (opA < opB);
    case (ctl.cmpKind)
      CK_EQ:   cmpRes = eqV;
      CK_NE:   cmpRes = !eqV;
      CK_GTS:  cmpRes = !ltS && !eqV;
      CK_GES:  cmpRes = !ltS;
      CK_LTS:  cmpRes = ltS;
      CK_LES:  cmpRes = ltS || eqV;
      CK_GTU:  cmpRes = !ltU && !eqV;
      CK_GEU:  cmpRes = !ltU;
      CK_LTU:  cmpRes = ltU;
      CK_LEU:  cmpRes = ltU || eqV;
      default: cmpRes = 1'b0;
    endcase
    flagNext = ctl.cmpEn ? cmpRes : flagIn;
  end

  always_comb begin
    relTarget  = pc + {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    takenNext  = ctl.jumpEn || (ctl.brCond && (flagIn == ctl.brOnSet));
    targetNext = '0;
    if (takenNext) targetNext = ctl.useReg ? regTarget : relTarget;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagOut   <= 1'b0;
      taken     <= 1'b0;
      target    <= '0;
      linkWe    <= 1'b0;
      linkData  <= '0;
      cmovValid <= 1'b0;
      cmovData  <= '0;
    end else begin
      flagOut   <= flagNext;
      taken     <= takenNext;
      target    <= targetNext;
      linkWe    <= ctl.linkEn;
      linkData  <= ctl.linkEn ? (pc + LINK_STEP) : '0;
      cmovValid <= ctl.cmovEn;
      cmovData  <= ctl.cmovEn ? (flagIn ? opA : opB) : '0;
    end
  end

  assign linkIdx = IDX_W'(LINK_REG);

  // R4: equality compare reaches the flag one cycle later
  a_r4_eq_flag: assert property (@(posedge clk) disable iff (rst)
    (ctl.cmpEn && ctl.cmpKind == CK_EQ) |=> (flagOut == ($past(opA) == $past(opB))));

  // R6: flag-set branch follows the flag
  a_r6_br_follows_flag: assert property (@(posedge clk) disable iff (rst)
    (ctl.brCond && ctl.brOnSet) |=> (taken == $past(flagIn)));

  // R9: link data is the transfer address plus two words
  a_r9_link_pc8: assert property (@(posedge clk) disable iff (rst)
    ctl.linkEn |=> (linkWe && linkData == $past(pc) + LINK_STEP));

  // R10: no target without a transfer
  a_r10_idle_target: assert property (@(posedge clk) disable iff (rst)
    !taken |-> (target == '0));

  // R11: a move never coincides with a transfer or a link write
  a_r11_cmov_alone: assert property (@(posedge clk) disable iff (rst)
    cmovValid |-> (!taken && !linkWe));

endmodule

// File: rtl/fcb_unit.sv
module fcb_unit
  import fcb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 26,
  parameter int OP_W     = 5,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic              flagIn,
  output logic              flagOut,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [ADDR_W-1:0] linkData,
  output logic              cmovValid,
  output logic [DATA_W-1:0] cmovData
);

  ctl_t ctl;

  fcb_ctrl #(.OP_W(OP_W)) i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctl     (ctl)
  );

  fcb_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .LINK_REG(LINK_REG)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .pc        (pc),
    .offset    (offset),
    .regTarget (regTarget),
    .flagIn    (flagIn),
    .flagOut   (flagOut),
    .taken     (taken),
    .target    (target),
    .linkWe    (linkWe),
    .linkIdx   (linkIdx),
    .linkData  (linkData),
    .cmovValid (cmovValid),
    .cmovData  (cmovData)
  );

endmodule

// File: tb/test_fcb_unit.sv
module test_fcb_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [4:0]  opCode;
  logic [31:0] opA, opB, pc, regTarget;
  logic [25:0] offset;
  logic        flagIn;
  logic        flagOut, taken, linkWe, cmovValid;
  logic [31:0] target, linkData, cmovData;
  logic [4:0]  linkIdx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fcb_unit i_fcb_unit (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .pc(pc), .offset(offset), .regTarget(regTarget),
    .flagIn(flagIn), .flagOut(flagOut), .taken(taken), .target(target),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData),
    .cmovValid(cmovValid), .cmovData(cmovData)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [4:0] op, logic [31:0] a, logic [31:0] b,
                       logic [31:0] p, int off, logic [31:0] rt, logic f);
    @(negedge clk);
    opValid = v; opCode = op; opA = a; opB = b; pc = p;
    offset = off[25:0]; regTarget = rt; flagIn = f;
    @(posedge clk);
    #1;
  endtask

  function automatic logic cmpExp(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      1: return a == b;
      2: return a != b;
      3: return $signed(a) > $signed(b);
      4: return $signed(a) >= $signed(b);
      5: return $signed(a) < $signed(b);
      6: return $signed(a) <= $signed(b);
      7: return a > b;
      8: return a >= b;
      9: return a < b;
      default: return a <= b;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFFFFFF;
    vals[3] = 32'h80000000; vals[4] = 32'hFFFFFFFF; vals[5] = 32'h5;
    rst = 1'b1; opValid = 0; opCode = 0; opA = 0; opB = 0; pc = 0;
    offset = 0; regTarget = 0; flagIn = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flag", {31'b0, flagOut}, 0);
    chk("R1 taken", {31'b0, taken}, 0);
    chk("R1 target", target, 0);
    chk("R1 linkWe", {31'b0, linkWe}, 0);
    chk("R1 linkIdx", {27'b0, linkIdx}, 9);
    chk("R1 cmov", {31'b0, cmovValid} | cmovData, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4 compare sweep; flagIn opposite to expected to catch pass-through
    for (int op = 1; op <= 10; op++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic e;
          e = cmpExp(op, vals[i], vals[j]);
          apply(1, 5'(op), vals[i], vals[j], 32'h100, 0, 0, !e);
          if (op <= 2) chk("R4 compare flag", {31'b0, flagOut}, {31'b0, e});
          else if (op <= 6) chk("R2 signed flag", {31'b0, flagOut}, {31'b0, e});
          else chk("R3 unsigned flag", {31'b0, flagOut}, {31'b0, e});
          chk("R10 compare no transfer", {31'b0, taken} | target, 0);
        end
      end
    end

    // R5 flag pass-through for non-compare and idle cycles
    for (int f = 0; f < 2; f++) begin
      apply(1, 5'd13, 1, 2, 32'h40, 1, 0, f[0]);
      chk("R5 flag through jump", {31'b0, flagOut}, f);
      apply(0, 5'd1, 3, 3, 0, 0, 0, f[0]);
      chk("R5 flag idle", {31'b0, flagOut}, f);
      apply(1, 5'd0, 3, 3, 0, 0, 0, f[0]);
      chk("R5 flag code0", {31'b0, flagOut}, f);
    end

    // R6 conditional branches, both polarities, forward and backward offsets
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 3; k++) begin
        int off;
        off = (k == 0) ? 3 : (k == 1) ? -2 : -33554432;
        apply(1, 5'd11, 0, 0, 32'h1000, off, 32'hDEAD, f[0]);
        chk("R6 bf taken", {31'b0, taken}, f);
        chk("R6 bf target", target, f ? 32'h1000 + 32'(off * 4) : 0);
        chk("R9 bf no link", {31'b0, linkWe} | linkData, 0);
        apply(1, 5'd12, 0, 0, 32'h1000, off, 32'hDEAD, f[0]);
        chk("R6 bnf taken", {31'b0, taken}, {31'b0, !f[0]});
        chk("R10 bnf target", target, !f[0] ? 32'h1000 + 32'(off * 4) : 0);
      end
    end

    // R7 R8 R9 unconditional transfers with both flag values
    for (int f = 0; f < 2; f++) begin
      apply(1, 5'd13, 0, 0, 32'h2000, -5, 32'h55, f[0]);
      chk("R7 j taken", {31'b0, taken}, 1);
      chk("R7 j target", target, 32'h2000 - 32'd20);
      chk("R9 j no link", {31'b0, linkWe}, 0);
      apply(1, 5'd14, 0, 0, 32'hFFFFFFFC, 7, 32'h55, f[0]);
      chk("R7 jal target", target, 32'hFFFFFFFC + 32'd28);
      chk("R9 jal link we", {31'b0, linkWe}, 1);
      chk("R9 jal link data", linkData, 32'h4);
      chk("R9 link idx", {27'b0, linkIdx}, 9);
      apply(1, 5'd15, 0, 0, 32'h3000, 4, 32'hCAFE0010, f[0]);
      chk("R8 jr taken", {31'b0, taken}, 1);
      chk("R8 jr target", target, 32'hCAFE0010);
      chk("R9 jr no link", {31'b0, linkWe}, 0);
      apply(1, 5'd16, 0, 0, 32'h3000, 4, 32'hBEEF0000, f[0]);
      chk("R8 jalr target", target, 32'hBEEF0000);
      chk("R9 jalr link data", linkData, 32'h3008);
    end

    // R11 conditional move
    for (int f = 0; f < 2; f++) begin
      apply(1, 5'd17, 32'hAAAA0001, 32'h5555FFFE, 32'h10, 1, 32'h20, f[0]);
      chk("R11 cmov valid", {31'b0, cmovValid}, 1);
      chk("R11 cmov data", cmovData, f ? 32'hAAAA0001 : 32'h5555FFFE);
      chk("R11 cmov no transfer", {31'b0, taken} | {31'b0, linkWe}, 0);
    end
    apply(1, 5'd1, 32'hAAAA0001, 32'h5555FFFE, 0, 0, 0, 1);
    chk("R11 cmov cleared", {31'b0, cmovValid} | cmovData, 0);

    // R12 idle and unassigned codes
    for (int op = 11; op <= 17; op++) begin
      apply(0, 5'(op), 1, 2, 32'h500, 1, 32'h600, 1);
      chk("R12 idle strobes", {29'b0, taken, linkWe, cmovValid}, 0);
    end
    for (int op = 18; op < 32; op++) begin
      apply(1, 5'(op), 1, 2, 32'h500, 1, 32'h600, 1);
      chk("R12 unassigned strobes", {29'b0, taken, linkWe, cmovValid}, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule